// File: doc/BRIEF.md
# Converter Power and Rate Sequencer

This block is the control state machine that walks a single sampling converter through its three phases: converting, resting between conversions, and serving a bus access. The serial port in front of it reports two events: a valid address acknowledge and the end of an access, where the access ended either by a stop condition or by the last data bit. The sequencer answers with enables for the converter core and for its voltage reference. It also drives a busy flag, which the port uses to refuse its address during a conversion, and a result-valid flag with a companion discard flag. The analog core is stood in for by a conversion timer that counts ticks of a shared timebase.

Two configuration fields arrive with a write strobe. The fast-rate field shortens the conversion period. The deep-sleep field makes the reference power down together with the converter when the next conversion ends, instead of staying up as it does in the default nap behaviour. A written configuration is held as pending and becomes active only when the next conversion starts. Once the reference is off, it comes back only on an address acknowledge. From that moment a warm-up counter runs. A conversion that starts before the warm-up has elapsed yields a result marked for discard.

States: `SEQ_CONV` (converting, busy), `SEQ_IDLE` (converter off, result held) and `SEQ_XFER` (access in progress). Transitions: `SEQ_CONV` to `SEQ_IDLE` when the conversion timer expires. `SEQ_IDLE` to `SEQ_XFER` on address acknowledge, which also wakes the reference if it is off. `SEQ_XFER` to `SEQ_CONV` on access done. Reset enters `SEQ_CONV` with the reference on.

Top module: `cnv_pwr_seq`

## Requirements
- R1: During and right after reset the block is in the converting state: conv_en=1, conv_busy=1, ref_en=1, result_valid=0, discard=0. The active configuration is the slow rate with nap power handling.
- R2: A conversion lasts SLOW_TICKS ticks when its active fast field is 0 and FAST_TICKS ticks when it is 1. conv_busy falls one clock after the clock that samples the final tick.
- R3: When a conversion with deep=0 ends, conv_en and conv_busy drop and result_valid rises on the same clock, while ref_en stays 1.
- R4: When a conversion with deep=1 ends, ref_en drops on the same clock as conv_en. ref_en never falls at any other time.
- R5: With the reference off, ref_en stays 0 through ticks and other events in the idle state. It rises on the clock after an address acknowledge, which also moves the block into the access state.
- R6: Address acknowledge and access done have no effect during a conversion: conv_busy stays 1 and the conversion runs its full length.
- R7: Access done during an access starts a conversion on the next clock and clears result_valid. Access done in the idle state is ignored. result_valid stays 1 from the end of a conversion until the next conversion starts.
- R8: A result is flagged with discard=1 when its conversion started before WARM_TICKS ticks had elapsed since the reference last powered up, reset counting as a power-up. Otherwise discard=0. discard is only ever 1 while result_valid is 1.
- R9: A configuration write (cfg_wr with cfg_fast, cfg_deep) takes effect only when the next conversion starts. A write during a conversion changes neither that conversion's length nor its power handling.
- R10: The converter is never enabled while the reference is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| addr_ack | input | 1 | Serial port acknowledged a valid address |
| access_done | input | 1 | Access ended by stop condition or last bit |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fast | input | 1 | 1 selects the short conversion period |
| cfg_deep | input | 1 | 1 powers the reference down after the next conversion |
| conv_en | output | 1 | Converter core enable |
| ref_en | output | 1 | Reference enable |
| conv_busy | output | 1 | Conversion in progress; the port refuses its address |
| result_valid | output | 1 | A finished result is available |
| discard | output | 1 | The available result was converted before reference warm-up ended |

## Verification
The hardest situation to reach is a conversion that starts inside the warm-up window after a wake from deep sleep. Reaching it takes three steps: a conversion must first run with deep=1 active, then an acknowledge must wake the reference, and then the access must close before WARM_TICKS ticks have passed. The vector table orders its entries to build that chain and varies the ticks spent inside the access on both sides of the warm-up limit. A directed opening sequence covers the reset-time warm-up, as well as events and configuration writes that land during a conversion.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_CONV = 2'd0,
        SEQ_IDLE = 2'd1,
        SEQ_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic fast;
        logic deep;
    } seq_cfg_t;

    localparam seq_cfg_t SEQ_CFG_RESET = '{fast: 1'b0, deep: 1'b0};

endpackage

// File: rtl/cnv_seq_tickcnt.sv
// Saturating tick counter: counts timebase ticks up to a limit and
// reports when the limit has been reached.
module cnv_seq_tickcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         reached
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && tick && (cnt_q != limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q == limit);

endmodule

// File: rtl/cnv_seq_cfg.sv
// Two-stage configuration holder: writes land in a pending copy,
// which is promoted to the active copy when a conversion starts.
module cnv_seq_cfg
    import cnv_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  seq_cfg_t wr_val,
    input  logic     load,
    output seq_cfg_t active
);

    seq_cfg_t pend_q;
    seq_cfg_t act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= SEQ_CFG_RESET;
        end else if (wr_en) begin
            pend_q <= wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= SEQ_CFG_RESET;
        end else if (load) begin
            act_q <= pend_q;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/cnv_pwr_seq.sv
module cnv_pwr_seq
    import cnv_seq_pkg::*;
#(
    parameter int unsigned SLOW_TICKS = 48,
    parameter int unsigned FAST_TICKS = 12,
    parameter int unsigned WARM_TICKS = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic addr_ack,
    input  logic access_done,
    input  logic cfg_wr,
    input  logic cfg_fast,
    input  logic cfg_deep,
    output logic conv_en,
    output logic ref_en,
    output logic conv_busy,
    output logic result_valid,
    output logic discard
);

    localparam int unsigned LEN_MAX = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int unsigned TOP_MAX = (LEN_MAX > WARM_TICKS) ? LEN_MAX : WARM_TICKS;
    localparam int unsigned CNT_W   = $clog2(TOP_MAX + 1);
    localparam logic [CNT_W-1:0] SLOW_L = CNT_W'(SLOW_TICKS);
    localparam logic [CNT_W-1:0] FAST_L = CNT_W'(FAST_TICKS);
    localparam logic [CNT_W-1:0] WARM_L = CNT_W'(WARM_TICKS);

    seq_state_e state_q, state_d;
    seq_cfg_t   cfg_act;
    seq_cfg_t   cfg_in;

    logic conv_reached;
    logic warm_ok;
    logic conv_start;
    logic conv_end;
    logic wake;
    logic ref_q;
    logic disc_pend_q;
    logic valid_q;
    logic disc_q;
    logic [CNT_W-1:0] conv_limit;

    // Event decode
    assign conv_start = (state_q == SEQ_XFER) && access_done;
    assign conv_end   = (state_q == SEQ_CONV) && conv_reached;
    assign wake       = (state_q == SEQ_IDLE) && addr_ack && !ref_q;
    assign conv_limit = cfg_act.fast ? FAST_L : SLOW_L;
    assign cfg_in     = '{fast: cfg_fast, deep: cfg_deep};

    cnv_seq_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .wr_val (cfg_in),
        .load   (conv_start),
        .active (cfg_act)
    );

    cnv_seq_tickcnt #(.W(CNT_W)) u_conv_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q != SEQ_CONV),
        .en      (1'b1),
        .tick    (tick),
        .limit   (conv_limit),
        .reached (conv_reached)
    );

    cnv_seq_tickcnt #(.W(CNT_W)) u_warm_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wake),
        .en      (ref_q),
        .tick    (tick),
        .limit   (WARM_L),
        .reached (warm_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_CONV;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_CONV: if (conv_reached) state_d = SEQ_IDLE;
            SEQ_IDLE: if (addr_ack)     state_d = SEQ_XFER;
            SEQ_XFER: if (access_done)  state_d = SEQ_CONV;
            default:                    state_d = SEQ_CONV;
        endcase
    end

    // Registered outputs and power control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q       <= 1'b1;
            disc_pend_q <= 1'b1;
            valid_q     <= 1'b0;
            disc_q      <= 1'b0;
        end else begin
            if (conv_end && cfg_act.deep) begin
                ref_q <= 1'b0;
            end else if (wake) begin
                ref_q <= 1'b1;
            end
            if (conv_start) begin
                disc_pend_q <= !warm_ok;
                valid_q     <= 1'b0;
                disc_q      <= 1'b0;
            end else if (conv_end) begin
                valid_q     <= 1'b1;
                disc_q      <= disc_pend_q;
            end
        end
    end

    assign conv_en      = (state_q == SEQ_CONV);
    assign conv_busy    = (state_q == SEQ_CONV);
    assign ref_en       = ref_q;
    assign result_valid = valid_q;
    assign discard      = disc_q;

endmodule

// File: rtl/cnv_pwr_seq_chk.sv
module cnv_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic addr_ack,
    input logic access_done,
    input logic conv_en,
    input logic ref_en,
    input logic conv_busy,
    input logic result_valid,
    input logic discard
);

    // R4: the reference turns off only as a conversion ends
    a_r4_ref_off_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_en) |-> ($past(conv_busy) && !conv_busy));

    // R5: the reference turns on only after an address acknowledge
    a_r5_ref_on_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en) |-> $past(addr_ack));

    // R3: a finished conversion leaves a valid result
    a_r3_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_busy) |-> result_valid);

    // R7: a conversion starts only after access done, with the result cleared
    a_r7_start_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy) |-> ($past(access_done) && !result_valid));

    // R8: discard only qualifies a valid result
    a_r8_discard_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> result_valid);

    // R10: no conversion without the reference
    a_r10_conv_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |-> ref_en);

endmodule

bind cnv_pwr_seq cnv_pwr_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_ack     (addr_ack),
    .access_done  (access_done),
    .conv_en      (conv_en),
    .ref_en       (ref_en),
    .conv_busy    (conv_busy),
    .result_valid (result_valid),
    .discard      (discard)
);

// File: tb/cnv_pwr_seq_bench.sv
module cnv_pwr_seq_bench;

    localparam int SLOW = 4;
    localparam int FAST = 2;
    localparam int WARM = 6;
    localparam int NVEC = 6;

    // fields: fast, deep, ticks spent in access, expected length,
    //         expected ref_en after end, expected discard
    localparam int VEC [NVEC][6] = '{
        '{0, 0, 0, SLOW, 1, 1},
        '{1, 0, 0, FAST, 1, 0},
        '{1, 1, 1, FAST, 0, 0},
        '{0, 0, 2, SLOW, 1, 1},
        '{0, 1, 0, SLOW, 0, 0},
        '{1, 0, 6, FAST, 1, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, addr_ack = 1'b0, access_done = 1'b0;
    logic cfg_wr = 1'b0, cfg_fast = 1'b0, cfg_deep = 1'b0;
    logic conv_en, ref_en, conv_busy, result_valid, discard;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cnv_pwr_seq #(.SLOW_TICKS(SLOW), .FAST_TICKS(FAST), .WARM_TICKS(WARM)) u_cnv_pwr_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr_ack(addr_ack),
        .access_done(access_done), .cfg_wr(cfg_wr), .cfg_fast(cfg_fast),
        .cfg_deep(cfg_deep), .conv_en(conv_en), .ref_en(ref_en),
        .conv_busy(conv_busy), .result_valid(result_valid), .discard(discard)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk) addr_ack = 1'b1;
        @(negedge clk) addr_ack = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk) access_done = 1'b1;
        @(negedge clk) access_done = 1'b0;
    endtask

    task automatic write_cfg(input logic f, input logic d);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_fast = f; cfg_deep = d; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (conv_busy && n < 20) begin
            pulse_tick();
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        // R1: values held during reset
        chk("R1 busy in reset", conv_busy, 1);
        chk("R1 ref in reset", ref_en, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 conv_en", conv_en, 1);
        chk("R1 conv_busy", conv_busy, 1);
        chk("R1 ref_en", ref_en, 1);
        chk("R1 result_valid", result_valid, 0);
        chk("R1 discard", discard, 0);

        // R6: bus events during a conversion are ignored
        pulse_ack();
        pulse_done();
        chk("R6 busy after events", conv_busy, 1);
        // R9: write during conversion must not affect it
        write_cfg(1'b1, 1'b1);
        measure(len);
        chk("R2 R6 R9 reset conversion length", len, SLOW);
        chk("R3 R9 ref stays on", ref_en, 1);
        chk("R3 conv_en off", conv_en, 0);
        chk("R3 result_valid", result_valid, 1);
        chk("R8 discard after reset warm-up", discard, 1);

        // R7: access done in idle is ignored
        pulse_done();
        repeat (2) @(negedge clk);
        chk("R7 idle done busy", conv_busy, 0);
        chk("R7 idle done valid", result_valid, 1);

        for (int v = 0; v < NVEC; v++) begin
            pulse_ack();
            chk($sformatf("R5 ref on after ack v%0d", v), ref_en, 1);
            chk($sformatf("R7 valid held in access v%0d", v), result_valid, 1);
            write_cfg(VEC[v][0][0], VEC[v][1][0]);
            for (int t = 0; t < VEC[v][2]; t++) pulse_tick();
            pulse_done();
            chk($sformatf("R7 busy after done v%0d", v), conv_busy, 1);
            chk($sformatf("R7 valid cleared v%0d", v), result_valid, 0);
            measure(len);
            chk($sformatf("R2 length v%0d", v), len, VEC[v][3]);
            chk($sformatf("R3 R4 ref after end v%0d", v), ref_en, VEC[v][4]);
            chk($sformatf("R3 conv_en off v%0d", v), conv_en, 0);
            chk($sformatf("R8 discard v%0d", v), discard, VEC[v][5]);
            if (VEC[v][4] == 0) begin
                // R5: reference stays off through idle activity
                pulse_tick();
                pulse_done();
                pulse_tick();
                chk($sformatf("R5 ref held off v%0d", v), ref_en, 0);
                chk($sformatf("R10 conv_en off v%0d", v), conv_en, 0);
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule